// File: doc/BRIEF.md
# Transmit Line Coder

This block sits on the transmit path between the packet framing logic and the modulator. It takes one data bit at a time and turns it into coded line symbols. Three coding options can be switched on in any combination through three configuration inputs. The first is a differential coder, which lets a receiver recover the data from a stream that may have arrived inverted. The second is a self-synchronizing scrambler that spreads the spectrum without adding bits. The third is a Manchester stage that sends two half-bit symbols per data bit.

The stages are chained in a fixed order: differential, then scrambler, then Manchester. The `chip_en` strobe paces the output, and each strobe that the block acts on produces one registered line symbol on the following cycle. A data bit is taken on a `chip_en` cycle with `in_valid` high, but only at a bit boundary. When Manchester coding is active, the strobe after the one that took the bit emits the second half of that bit and does not take a new data bit. The Manchester setting is captured with each data bit, so a change only takes effect at the next bit boundary.

Top module: `line_coder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` and `out_bit` are 0. Reset sets the differential level to 0 and clears every scrambler register bit.
- R2: With all options off, a bit taken on a `chip_en` cycle with `in_valid` high appears unchanged on `out_bit`, with `out_valid` high for exactly one cycle, on the cycle after that strobe.
- R3: With `cfg_diff` high, each data bit of 1 toggles the coded level and each 0 keeps it. The level starts at 0, and the coded level is the value passed on to the next stage.
- R4: With only `cfg_diff` high, XOR of two consecutive output symbols gives the data bit back. This is true both for the stream as sent and for its bitwise inverse, from the second bit onward.
- R5: With `cfg_scram` high, each scrambler output equals its input XOR the scrambler output 12 bits earlier XOR the output 17 bits earlier. Outputs from before reset count as 0. One output bit is produced per input bit.
- R6: A receiver that XORs each received bit with the received bits 12 and 17 positions earlier recovers the data from any starting state, from the 18th bit onward.
- R7: With only `cfg_scram` high and a constant input of 1, the output over 64 bits is neither constant nor periodic with any period from 1 to 8.
- R8: With Manchester active, a stage input of 1 is sent as the symbol 1 followed by 0, and a 0 as 0 followed by 1. The two halves go out on two successive acted-on `chip_en` strobes.
- R9: During the second half of a Manchester bit, `in_valid` and `in_bit` are ignored, and no coder state advances.
- R10: A change of `cfg_manch` applies only from the next data bit taken; a bit already started completes under the setting it was taken with.
- R11: In a cycle without `chip_en`, `out_valid` is 0 on the next cycle and no input is taken, even if `in_valid` is high.
- R12: With all options on, the symbols equal Manchester coding of the scrambled result of the differentially coded data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_diff | input | 1 | Enable differential coding |
| cfg_scram | input | 1 | Enable spectral-shaping scrambler |
| cfg_manch | input | 1 | Enable Manchester coding (captured per bit) |
| in_bit | input | 1 | Data bit |
| in_valid | input | 1 | Data bit is offered |
| chip_en | input | 1 | Output symbol strobe |
| out_bit | output | 1 | Coded line symbol |
| out_valid | output | 1 | `out_bit` carries a new symbol this cycle |

## Verification
The bench runs all eight option combinations on random data and compares every symbol with a model that keeps the history of scrambler outputs. A wrong tap or a missing feedback path would show up as a mismatch within 17 bits, and a wrong stage order would corrupt the combined mode. Idle cycles with `in_valid` high but no `chip_en` are placed between strobes, and random `in_valid` values are driven during second halves. A design that took data on those cycles would fall out of step with the model. It also flips `cfg_manch` in the middle of a bit, which catches a coder that drops or changes the pending second half. Separate checks decode the inverted differential stream, descramble from a garbage starting state, and look for short periods in the scrambled output of an all-ones input.

// File: rtl/line_coder_pkg.sv
package line_coder_pkg;
  localparam int DEF_SCR_LEN = 17;
  localparam int DEF_TAP_A   = 12;
  localparam int DEF_TAP_B   = 17;

  // Half-bit pair for Manchester: {first, second}
  function automatic logic [1:0] manch_pair(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction

  // Differential step: new level from old level and data bit
  function automatic logic diff_next(input logic lvl, input logic b);
    return lvl ^ b;
  endfunction
endpackage

// File: rtl/line_coder_diff.sv
module line_coder_diff (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic step,
  input  logic d_in,
  output logic d_out
);
  import line_coder_pkg::*;
  logic lvl;

  assign d_out = enable ? diff_next(lvl, d_in) : d_in;

  always_ff @(posedge clk) begin
    if (!rst_n)                lvl <= 1'b0;
    else if (step && enable)   lvl <= d_out;
  end
endmodule

// File: rtl/line_coder_scram.sv
module line_coder_scram #(
  parameter int LEN   = 17,
  parameter int TAP_A = 12,
  parameter int TAP_B = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic step,
  input  logic d_in,
  output logic d_out
);
  logic [LEN-1:0] sr;   // sr[0] is the most recent output
  logic fb;

  assign fb    = sr[TAP_A-1] ^ sr[TAP_B-1];
  assign d_out = enable ? (d_in ^ fb) : d_in;

  always_ff @(posedge clk) begin
    if (!rst_n)               sr <= '0;
    else if (step && enable)  sr <= {sr[LEN-2:0], d_out};
  end
endmodule

// File: rtl/line_coder_manch.sv
module line_coder_manch (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic take,
  input  logic sym,
  input  logic mode_req,
  output logic out_bit,
  output logic out_valid,
  output logic half2,
  output logic mode_act
);
  import line_coder_pkg::*;
  logic [1:0] pair;
  logic       second;

  assign pair = manch_pair(sym);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
      half2     <= 1'b0;
      mode_act  <= 1'b0;
      second    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (take) begin
        mode_act  <= mode_req;
        out_bit   <= mode_req ? pair[1] : sym;
        second    <= pair[0];
        half2     <= mode_req;
        out_valid <= 1'b1;
      end else if (chip_en && half2) begin
        out_bit   <= second;
        half2     <= 1'b0;
        out_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/line_coder.sv
module line_coder #(
  parameter int SCR_LEN = line_coder_pkg::DEF_SCR_LEN,
  parameter int TAP_A   = line_coder_pkg::DEF_TAP_A,
  parameter int TAP_B   = line_coder_pkg::DEF_TAP_B
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_diff,
  input  logic cfg_scram,
  input  logic cfg_manch,
  input  logic in_bit,
  input  logic in_valid,
  input  logic chip_en,
  output logic out_bit,
  output logic out_valid
);
  logic take_w, half2_w, mode_act_w, diff_w, scr_w;

  // A data bit is taken only at a bit boundary
  assign take_w = chip_en && in_valid && !half2_w;

  line_coder_diff u_diff (
    .clk(clk), .rst_n(rst_n), .enable(cfg_diff), .step(take_w),
    .d_in(in_bit), .d_out(diff_w)
  );

  line_coder_scram #(.LEN(SCR_LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_scram (
    .clk(clk), .rst_n(rst_n), .enable(cfg_scram), .step(take_w),
    .d_in(diff_w), .d_out(scr_w)
  );

  line_coder_manch u_manch (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .take(take_w),
    .sym(scr_w), .mode_req(cfg_manch), .out_bit(out_bit),
    .out_valid(out_valid), .half2(half2_w), .mode_act(mode_act_w)
  );
endmodule

// File: rtl/line_coder_chk.sv
module line_coder_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic in_valid,
  input logic out_valid,
  input logic out_bit,
  input logic half2,
  input logic take,
  input logic mode_act
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_bit);
  // R11
  a_r11_no_chip: assert property (@(posedge clk) disable iff (!rst_n) !chip_en |=> !out_valid);
  // R8: second half is the complement of the first
  a_r8_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    (half2 && chip_en) |=> (out_valid && out_bit != $past(out_bit)));
  // R9: no bit taken during a second half
  a_r9_no_take_half2: assert property (@(posedge clk) disable iff (!rst_n)
    (half2 && chip_en && in_valid) |=> !half2);
  // R10: Manchester setting only moves at a bit boundary
  a_r10_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(mode_act));
  // R2: one symbol per acted-on strobe
  a_r2_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(chip_en));
endmodule

bind line_coder line_coder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .in_valid(in_valid),
  .out_valid(out_valid), .out_bit(out_bit), .half2(half2_w),
  .take(take_w), .mode_act(mode_act_w)
);

// File: tb/line_coder_bench.sv
module line_coder_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_diff = 0, cfg_scram = 0, cfg_manch = 0;
  logic in_bit = 0, in_valid = 0, chip_en = 0;
  logic out_bit, out_valid;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  line_coder u_line_coder (.*);

  // bench model state
  int m_lvl;
  int yh [0:4095];
  int ny;
  int o_bit, o_val;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; chip_en = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_lvl = 0; ny = 0;
  endtask

  task automatic step(input logic en, input logic v, input logic b);
    @(negedge clk);
    chip_en = en; in_valid = v; in_bit = b;
    @(posedge clk); #1;
    o_bit = out_bit; o_val = out_valid;
    chip_en = 0; in_valid = 0;
  endtask

  function automatic int model_bit(input int b, input bit dm, input bit sm);
    int d, s, t12, t17;
    d = b;
    if (dm) begin d = (m_lvl + b) % 2; m_lvl = d; end
    s = d;
    if (sm) begin
      t12 = (ny >= 12) ? yh[ny-12] : 0;
      t17 = (ny >= 17) ? yh[ny-17] : 0;
      s = (d + t12 + t17) % 2;
      yh[ny] = s; ny++;
    end
    return s;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rec [0:63];
    do_reset();
    @(negedge clk);
    check("R1 out_valid", out_valid, 0);
    check("R1 out_bit", out_bit, 0);

    // Sweep all option combinations (R2 R3 R5 R8 R9 R11 R12)
    for (int mode = 0; mode < 8; mode++) begin
      cfg_diff = mode[0]; cfg_scram = mode[1]; cfg_manch = mode[2];
      do_reset();
      for (int k = 0; k < 40; k++) begin
        int b, s;
        b = $urandom % 2;
        if (k % 5 == 3) begin
          step(0, 1, ~b[0]);          // R11: no strobe, nothing taken
          check("R11 idle", o_val, 0);
        end
        s = model_bit(b, mode[0], mode[1]);
        step(1, 1, b[0]);
        check("R2 valid", o_val, 1);
        check(mode == 7 ? "R12 combined" : mode[2] ? "R8 first" :
              mode[1] ? "R5 scram" : mode[0] ? "R3 diff" : "R2 plain", o_bit, s);
        if (mode[2]) begin
          step(1, $urandom % 2, $urandom % 2);   // R9: input ignored
          check("R9 valid", o_val, 1);
          check("R8 second", o_bit, 1 - s);
        end
      end
    end

    // R4: differential decode, as sent and inverted
    cfg_diff = 1; cfg_scram = 0; cfg_manch = 0;
    do_reset();
    begin
      int db [0:39];
      for (int i = 0; i < 40; i++) begin
        db[i] = $urandom % 2;
        step(1, 1, db[i][0]);
        rec[i] = o_bit;
      end
      for (int i = 1; i < 40; i++) begin
        check("R4 direct", rec[i] ^ rec[i-1], db[i]);
        check("R4 inverted", (1 - rec[i]) ^ (1 - rec[i-1]), db[i]);
      end
    end

    // R6: descramble from garbage state
    cfg_diff = 0; cfg_scram = 1;
    do_reset();
    begin
      int db [0:59];
      logic [16:0] rx;
      rx = 17'h1a5c3;
      for (int i = 0; i < 60; i++) begin
        int r;
        db[i] = $urandom % 2;
        step(1, 1, db[i][0]);
        r = o_bit ^ rx[11] ^ rx[16];
        rx = {rx[15:0], o_bit[0]};
        if (i >= 17) check("R6 descramble", r, db[i]);
      end
    end

    // R7: constant ones input
    do_reset();
    begin
      int ones;
      ones = 0;
      for (int i = 0; i < 64; i++) begin
        step(1, 1, 1'b1);
        rec[i] = o_bit; ones += o_bit;
      end
      check("R7 not constant", (ones > 0 && ones < 64) ? 1 : 0, 1);
      for (int p = 1; p <= 8; p++) begin
        int diff;
        diff = 0;
        for (int i = 0; i + p < 64; i++) if (rec[i] != rec[i+p]) diff = 1;
        check("R7 no short period", diff, 1);
      end
    end

    // R10: Manchester change mid-bit
    cfg_scram = 0; cfg_manch = 1;
    do_reset();
    step(1, 1, 1'b1);
    check("R10 first half", o_bit, 1);
    cfg_manch = 0;
    step(1, 1, 1'b0);
    check("R10 pending half kept", o_bit, 0);
    check("R10 pending valid", o_val, 1);
    step(1, 1, 1'b1);
    check("R10 new setting", o_bit, 1);
    step(1, 0, 1'b0);
    check("R10 no second half", o_val, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule